// File: doc/BRIEF.md
# Chip-Select Bus Cycle Controller

This block is the master side of a synchronous external bus. An internal requester hands it one read or write at a time. The controller decodes the address to pick one of several chip-select regions. It drives the address, direction, write data and that region's active-low chip select. It then waits for the cycle to end and returns a one-clock done pulse, together with the read data.

Each region has two settings: a wait-state count and an automatic-acknowledge enable. When the enable is set, the controller makes its own acknowledge once the programmed number of wait clocks has passed. The peripheral may also pull the active-low acknowledge input, and whichever acknowledge comes first ends the cycle. When the enable is clear, only the peripheral can end the cycle, and there is no timeout. Once termination is seen, chip select is released on a fixed schedule. The controller never waits for acknowledge to go high again, so an acknowledge stuck low cannot hang the bus.

States: `ST_IDLE` (no cycle), `ST_ADDR` (address out, chip select low), `ST_WAIT` (waiting for termination), `ST_DONE` (completion, chip select still low), `ST_REL` (chip select high, done pulse). The transitions are:
- IDLE→ADDR on a request.
- ADDR→WAIT always.
- WAIT→WAIT while no termination is seen.
- WAIT→DONE on termination.
- DONE→REL always.
- REL→IDLE always.

Top module: `csc_bus_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it drops, all chip selects are high (negated), `done` is 0 and `bus_we` is 0.
- R2: A request taken in ST_IDLE drives chip select low on the next cycle. The region index is `req_addr[ADDR_W-1 -: SEL_W]`, and only that region's `bus_cs_n` bit goes low, so at most one is ever low. During that cycle `bus_addr` equals the request address and `bus_we` is 1 for a write and 0 for a read.
- R3: `bus_ack_n` is sampled only in ST_WAIT. If it is sampled low in the k-th wait cycle (k ≥ 1), chip select is low for exactly k+2 cycles and goes high on the second clock edge after that sample.
- R4: Acknowledge held low over the whole cycle, including ST_ADDR, still ends the cycle. Chip select is low for exactly 3 cycles, and low acknowledge in ST_ADDR does not skip the wait state.
- R5: When automatic acknowledge is enabled for region r (`cfg_auto[r]`=1) with wait count N (`cfg_ws[r*6 +: 6]`, 0..63), and no external acknowledge arrives, chip select is low for exactly N+3 cycles.
- R6: When automatic acknowledge is disabled and the peripheral does not acknowledge, the cycle stays in ST_WAIT with chip select low for as long as acknowledge stays high.
- R7: When automatic acknowledge is enabled and the peripheral also acknowledges, the earlier of the two ends the cycle.
- R8: For a read, `rdata` takes the value `bus_rdata` had at the clock edge where termination was sampled. It keeps that value after the cycle, whatever `bus_rdata` does later.
- R9: While chip select is low, `bus_addr`, `bus_we` and `bus_wdata` stay constant, and for a write `bus_wdata` equals the request data.
- R10: `done` is high for exactly one clock, in the cycle right after chip select goes high.
- R11: A request raised while a cycle is in progress is ignored. No second chip-select cycle follows the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, sampled in idle only |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address; top SEL_W bits select the region |
| req_wdata | input | DATA_W | Write data |
| done | output | 1 | One-clock completion pulse |
| rdata | output | DATA_W | Captured read data |
| cfg_ws | input | NUM_CS*WS_W | Wait-state count per region, region r at [r*WS_W +: WS_W] |
| cfg_auto | input | NUM_CS | Automatic acknowledge enable per region |
| bus_cs_n | output | NUM_CS | Active-low chip selects |
| bus_addr | output | ADDR_W | Bus address |
| bus_we | output | 1 | Direction, 1 = write |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdata | input | DATA_W | Bus read data |
| bus_ack_n | input | 1 | Active-low transfer acknowledge |

## Verification
Some properties are checked on every cycle:
- at most one chip select is low;
- an acknowledge sampled in ST_WAIT leads to ST_DONE;
- ST_DONE always moves to release with chip select high, whatever acknowledge is doing;
- address, direction and write data do not move while chip select is low;
- done is a single pulse with chip select high;
- a cycle can begin only from idle.

Only the directed scenarios can show the exact chip-select lengths for a given wait count or acknowledge position, and the first-wins behaviour with both sources active. They also show the long wait with no automatic acknowledge and which `bus_rdata` sample ends up in `rdata`.

// File: rtl/csc_pkg.sv
package csc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WAIT,
        ST_DONE,
        ST_REL
    } csc_state_e;
endpackage

// File: rtl/csc_region_sel.sv
module csc_region_sel #(
    parameter int ADDR_W = 16,
    parameter int NUM_CS = 4,
    parameter int WS_W   = 6,
    localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic [ADDR_W-1:0]      addr,
    input  logic [NUM_CS*WS_W-1:0] cfg_ws,
    input  logic [NUM_CS-1:0]      cfg_auto,
    output logic [SEL_W-1:0]       region,
    output logic [WS_W-1:0]        ws,
    output logic                   auto_en
);
    logic [WS_W-1:0] ws_arr [NUM_CS];

    for (genvar g = 0; g < NUM_CS; g++) begin : g_unpack
        assign ws_arr[g] = cfg_ws[g*WS_W +: WS_W];
    end

    always_comb begin
        region  = addr[ADDR_W-1 -: SEL_W];
        ws      = '0;
        auto_en = 1'b0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (region == SEL_W'(i)) begin
                ws      = ws_arr[i];
                auto_en = cfg_auto[i];
            end
        end
    end
endmodule

// File: rtl/csc_wait_timer.sv
module csc_wait_timer #(
    parameter int WS_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            run,
    input  logic [WS_W-1:0] ws,
    input  logic            auto_en,
    output logic            int_ack
);
    logic [WS_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (run && cnt != {WS_W{1'b1}}) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign int_ack = auto_en && run && (cnt == ws);
endmodule

// File: rtl/csc_fsm.sv
module csc_fsm
    import csc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  logic       term,
    output csc_state_e state,
    output logic       accept,
    output logic       capture,
    output logic       cs_act,
    output logic       cnt_clear,
    output logic       cnt_run,
    output logic       done
);
    csc_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (req)  nxt = ST_ADDR;
            ST_ADDR:           nxt = ST_WAIT;
            ST_WAIT: if (term) nxt = ST_DONE;
            ST_DONE:           nxt = ST_REL;
            ST_REL:            nxt = ST_IDLE;
            default:           nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        accept    = 1'b0;
        capture   = 1'b0;
        cs_act    = 1'b0;
        cnt_clear = 1'b0;
        cnt_run   = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_IDLE: accept = req;
            ST_ADDR: begin
                cs_act    = 1'b1;
                cnt_clear = 1'b1;
            end
            ST_WAIT: begin
                cs_act  = 1'b1;
                cnt_run = 1'b1;
                capture = term;
            end
            ST_DONE: cs_act = 1'b1;
            ST_REL:  done   = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/csc_bus_ctrl.sv
module csc_bus_ctrl
    import csc_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int WS_W   = 6,
    localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req,
    input  logic                   req_we,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   done,
    output logic [DATA_W-1:0]      rdata,
    input  logic [NUM_CS*WS_W-1:0] cfg_ws,
    input  logic [NUM_CS-1:0]      cfg_auto,
    output logic [NUM_CS-1:0]      bus_cs_n,
    output logic [ADDR_W-1:0]      bus_addr,
    output logic                   bus_we,
    output logic [DATA_W-1:0]      bus_wdata,
    input  logic [DATA_W-1:0]      bus_rdata,
    input  logic                   bus_ack_n
);
    csc_state_e      state;
    logic            accept, capture, cs_act, cnt_clear, cnt_run;
    logic            int_ack, term;
    logic [SEL_W-1:0] sel_region, region_q;
    logic [WS_W-1:0] sel_ws, ws_q;
    logic            sel_auto, auto_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic            we_q;

    csc_region_sel #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS), .WS_W(WS_W)) u_sel (
        .addr    (req_addr),
        .cfg_ws  (cfg_ws),
        .cfg_auto(cfg_auto),
        .region  (sel_region),
        .ws      (sel_ws),
        .auto_en (sel_auto)
    );

    csc_wait_timer #(.WS_W(WS_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clear  (cnt_clear),
        .run    (cnt_run),
        .ws     (ws_q),
        .auto_en(auto_q),
        .int_ack(int_ack)
    );

    assign term = int_ack || !bus_ack_n;

    csc_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .term     (term),
        .state    (state),
        .accept   (accept),
        .capture  (capture),
        .cs_act   (cs_act),
        .cnt_clear(cnt_clear),
        .cnt_run  (cnt_run),
        .done     (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            wdata_q  <= '0;
            we_q     <= 1'b0;
            region_q <= '0;
            ws_q     <= '0;
            auto_q   <= 1'b0;
        end else if (accept) begin
            addr_q   <= req_addr;
            wdata_q  <= req_wdata;
            we_q     <= req_we;
            region_q <= sel_region;
            ws_q     <= sel_ws;
            auto_q   <= sel_auto;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                  rdata <= '0;
        else if (capture && !we_q) rdata <= bus_rdata;
    end

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign bus_cs_n[g] = !(cs_act && (region_q == SEL_W'(g)));
    end

    assign bus_addr  = addr_q;
    assign bus_wdata = wdata_q;
    assign bus_we    = we_q && cs_act;
endmodule

// File: rtl/csc_bus_ctrl_chk.sv
module csc_bus_ctrl_chk
    import csc_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input csc_state_e        state,
    input logic              bus_ack_n,
    input logic [NUM_CS-1:0] bus_cs_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_we,
    input logic              done
);
    logic cs_low;
    assign cs_low = !(&bus_cs_n);

    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&bus_cs_n && !done && !bus_we));

    a_r2_cs_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~bus_cs_n));

    a_r3_ack_to_done: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && !bus_ack_n) |=> (state == ST_DONE && cs_low));

    a_r4_release_no_hold: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE) |=> (state == ST_REL && &bus_cs_n));

    a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (cs_low && $past(cs_low)) |->
            ($stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we)));

    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r10_done_cs_high: assert property (@(posedge clk) disable iff (rst)
        done |-> &bus_cs_n);

    a_r11_start_from_idle: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> (state != ST_ADDR));
endmodule

bind csc_bus_ctrl csc_bus_ctrl_chk #(
    .NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .state    (state),
    .bus_ack_n(bus_ack_n),
    .bus_cs_n (bus_cs_n),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_we   (bus_we),
    .done     (done)
);

// File: tb/csc_bus_ctrl_tb.sv
module csc_bus_ctrl_tb;
    localparam int NUM_CS = 4;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int WS_W   = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0, req_we = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic done;
    logic [DATA_W-1:0] rdata;
    logic [NUM_CS*WS_W-1:0] cfg_ws = '0;
    logic [NUM_CS-1:0] cfg_auto = '0;
    logic [NUM_CS-1:0] bus_cs_n;
    logic [ADDR_W-1:0] bus_addr;
    logic bus_we;
    logic [DATA_W-1:0] bus_wdata;
    logic [DATA_W-1:0] bus_rdata = '0;
    logic bus_ack_n = 1'b1;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    csc_bus_ctrl #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WS_W(WS_W)) u_dut (
        .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .done(done), .rdata(rdata), .cfg_ws(cfg_ws),
        .cfg_auto(cfg_auto), .bus_cs_n(bus_cs_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack_n(bus_ack_n)
    );

    task automatic check(input bit ok, input string req_tag, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req_tag, what, act, exp);
        end
    endtask

    task automatic set_region(input int r, input logic auto_en, input int ws);
        cfg_auto[r] = auto_en;
        cfg_ws[r*WS_W +: WS_W] = WS_W'(ws);
    endtask

    // Runs one cycle. ack_at = wait cycle in which ack is driven low (0 = never);
    // stuck = ack held low for the whole cycle; inject = extra request while busy.
    task automatic run_cycle(input string req_tag, input logic we, input logic [ADDR_W-1:0] addr,
                             input logic [DATA_W-1:0] wd, input int ack_at, input bit stuck,
                             input bit inject, input int exp_len);
        int region;
        int len;
        int i;
        bit hold_ok;
        logic [DATA_W-1:0] rbase;
        region  = int'(addr[ADDR_W-1 -: 2]);
        rbase   = 16'hA500 ^ addr;
        hold_ok = 1'b1;
        @(negedge clk);
        req = 1'b1; req_we = we; req_addr = addr; req_wdata = wd;
        if (stuck) bus_ack_n = 1'b0;
        @(negedge clk);
        req = 1'b0;
        i = 1;
        len = 0;
        while (bus_cs_n[region] == 1'b0 && i < 400) begin
            len++;
            if (i == 1) begin
                check(bus_cs_n == ~(NUM_CS'(1) << region), "R2", "cs pattern", bus_cs_n, ~(NUM_CS'(1) << region));
                check(bus_addr == addr, "R2", "address", bus_addr, addr);
                check(bus_we == we, "R2", "direction", bus_we, we);
            end
            if (bus_addr != addr || bus_we != we || (we && bus_wdata != wd)) hold_ok = 1'b0;
            bus_rdata = rbase ^ DATA_W'(i);
            if (!stuck) bus_ack_n = (ack_at > 0 && i == ack_at + 1) ? 1'b0 : 1'b1;
            if (inject && i == 2) begin
                req = 1'b1; req_we = 1'b0; req_addr = addr ^ 16'h4000;
            end else begin
                req = 1'b0;
            end
            @(negedge clk);
            i++;
        end
        bus_ack_n = 1'b1;
        req = 1'b0;
        check(len == exp_len, req_tag, "cs low cycles", len, exp_len);
        check(hold_ok, "R9", "addr/dir/wdata held while cs low", hold_ok, 1);
        check(done == 1'b1 && &bus_cs_n, "R10", "done with cs high", {done, bus_cs_n}, {1'b1, {NUM_CS{1'b1}}});
        if (!we) check(rdata == (rbase ^ DATA_W'(exp_len - 1)), "R8", "read data at term edge",
                       rdata, rbase ^ DATA_W'(exp_len - 1));
        bus_rdata = 16'hDEAD;
        @(negedge clk);
        check(done == 1'b0, "R10", "done single clock", done, 0);
        if (!we) check(rdata == (rbase ^ DATA_W'(exp_len - 1)), "R8", "read data kept",
                       rdata, rbase ^ DATA_W'(exp_len - 1));
        if (inject) begin
            for (int k = 0; k < 3; k++) begin
                check(&bus_cs_n, "R11", "no cycle from busy request", bus_cs_n, {NUM_CS{1'b1}});
                @(negedge clk);
            end
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(&bus_cs_n && !done && !bus_we, "R1", "outputs in reset", {done, bus_we, bus_cs_n}, {2'b00, {NUM_CS{1'b1}}});
        rst = 1'b0;
        @(negedge clk);
        check(&bus_cs_n && !done && !bus_we, "R1", "outputs after reset", {done, bus_we, bus_cs_n}, {2'b00, {NUM_CS{1'b1}}});
    endtask

    task automatic t_external;
        set_region(0, 1'b0, 0);
        set_region(1, 1'b0, 5);
        run_cycle("R3", 1'b0, 16'h0123, 16'h0, 1, 1'b0, 1'b0, 3);
        run_cycle("R3", 1'b1, 16'h4456, 16'hBEEF, 4, 1'b0, 1'b0, 6);
        run_cycle("R3", 1'b0, 16'h4AAA, 16'h0, 7, 1'b0, 1'b0, 9);
    endtask

    task automatic t_stuck;
        set_region(2, 1'b0, 40);
        run_cycle("R4", 1'b0, 16'h8010, 16'h0, 0, 1'b1, 1'b0, 3);
        run_cycle("R4", 1'b1, 16'h8020, 16'h1234, 0, 1'b1, 1'b0, 3);
    endtask

    task automatic t_internal;
        set_region(3, 1'b1, 0);
        run_cycle("R5", 1'b0, 16'hC001, 16'h0, 0, 1'b0, 1'b0, 3);
        set_region(3, 1'b1, 5);
        run_cycle("R5", 1'b1, 16'hC002, 16'h5A5A, 0, 1'b0, 1'b0, 8);
        set_region(3, 1'b1, 63);
        run_cycle("R5", 1'b0, 16'hC003, 16'h0, 0, 1'b0, 1'b0, 66);
    endtask

    task automatic t_no_ack;
        set_region(1, 1'b0, 2);
        run_cycle("R6", 1'b0, 16'h4321, 16'h0, 150, 1'b0, 1'b0, 152);
    endtask

    task automatic t_first_wins;
        set_region(0, 1'b1, 20);
        run_cycle("R7", 1'b0, 16'h0777, 16'h0, 3, 1'b0, 1'b0, 5);
        set_region(0, 1'b1, 2);
        run_cycle("R7", 1'b0, 16'h0888, 16'h0, 10, 1'b0, 1'b0, 5);
    endtask

    task automatic t_busy_req;
        set_region(2, 1'b1, 3);
        run_cycle("R11", 1'b1, 16'h8ABC, 16'hCAFE, 0, 1'b0, 1'b1, 6);
    endtask

    initial begin
        #(8 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_external();
        t_stuck();
        t_internal();
        t_no_ack();
        t_first_wins();
        t_busy_req();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule